// File: doc/BRIEF.md
# Dual-Channel Disk Controller IO Address Decoder

This block sits in front of a two-channel disk controller and classifies every host IO access. Five windows are programmable through a small configuration write port: a command window and a control window for each of the two channels, plus one bus-master window shared by both channels. Each window has a base address set at run time and a fixed size set by a parameter. For each access the block reports one of four things. On a hit it gives the window kind, the channel, the offset inside the window and the index of the one of four devices that the access targets. Otherwise it flags an error, or it does nothing.

Each channel carries a master device and a slave device. The block keeps one shadow bit per channel, copied from writes to the device-select register of that channel's command window. The target index is then twice the channel number plus that channel's shadow bit. The bus-master window is split between the channels by offset. Decode results appear on registered outputs one cycle after the access is presented.

Top module: `dchan_io_decode`

## Requirements
- R1: A configuration write (`cfg_we`, `cfg_sel` = 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus-master) loads a window base only when the written value is nonzero; a zero write leaves the base unchanged. A window whose base is still zero never matches. A configuration write takes effect for accesses from the next cycle on.
- R2: An address hits a window when base <= address < base + size, computed without wrap-around. On a hit, `dec_kind` reads 1 for a command window, 2 for a control window and 3 for the bus-master window. `dec_chan` is 0 for primary and 1 for secondary, and `dec_offset` is address minus base.
- R3: In the bus-master window, an offset below `BM_SPLIT` (default 8) belongs to channel 0 and any larger offset belongs to channel 1.
- R4: When windows overlap, the first match wins, in this order: primary command, primary control, secondary command, secondary control, bus-master.
- R5: An accepted write to command-window offset `SEL_OFF` (default 6) copies bit `SEL_BIT` (default 4) of `acc_wdata` into that channel's shadow bit. The same access already reports the new value. Reads, other offsets and control-window writes leave the shadow unchanged. `dec_dev` = 2 x channel + shadow bit.
- R6: After reset, both shadow bits are 0, so every channel targets its master device.
- R7: `acc_size` is 0 for byte, 1 for word and 2 for dword; 3 is illegal. A dword access to a command or control window, or any access of size 3, is rejected. It raises `dec_err`, reports no hit and changes no shadow bit.
- R8: While `io_space_en` is low, an access produces neither a hit nor an error and changes no shadow bit.
- R9: An enabled access that matches no window raises `dec_err` for one cycle and gives `dec_valid` = 0. `dec_valid` and `dec_err` are never high together.
- R10: Outputs are registered and reflect the access of the previous cycle. With no access, or after reset, `dec_valid` and `dec_err` are low and `dec_kind`, `dec_chan`, `dec_offset` and `dec_dev` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_space_en | input | 1 | Global enable for IO decoding |
| cfg_we | input | 1 | Base write strobe |
| cfg_sel | input | 3 | Window selected for the base write |
| cfg_wdata | input | AW | New base value |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_size | input | 2 | Access size code |
| acc_addr | input | AW | Access address |
| acc_wdata | input | 8 | Low byte of the write data |
| dec_valid | output | 1 | Accepted hit for previous access |
| dec_err | output | 1 | Previous access was rejected or missed |
| dec_kind | output | 2 | Window kind of the hit |
| dec_chan | output | 1 | Channel of the hit |
| dec_offset | output | OW | Offset within the window |
| dec_dev | output | 2 | Target device index |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, window sizes 8, 4, 8, 4 and 16, a split point of 8, and the select bit at bit 4 of offset 6. A 16-bit space is small enough for the bench to place the bus-master window at 0xFFF8. Its nominal end then lies past the top of the address space, which exercises the no-wrap comparison. The small sizes also let the bench program overlapping windows and hit each window's first and last byte with a few directed accesses, before a long run of pseudo-random accesses around every window.

// File: rtl/dcd_pkg.sv
// Shared types for the dual-channel IO decoder.
// Assumes the window order below; the priority encoder relies on it.
package dcd_pkg;
    localparam int NUM_WIN = 5;
    localparam int W_PCMD  = 0;
    localparam int W_PCTL  = 1;
    localparam int W_SCMD  = 2;
    localparam int W_SCTL  = 3;
    localparam int W_BM    = 4;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_BM   = 2'd3
    } win_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    // Kind of a window index.
    function automatic win_kind_e kind_of(input int idx);
        if (idx == W_BM)          return KIND_BM;
        else if (idx % 2 == 0)    return KIND_CMD;
        else                      return KIND_CTRL;
    endfunction
endpackage

// File: rtl/dcd_base_regs.sv
// Holds one programmable base per window.
// Assumes cfg_sel values at or above NUM_WIN select nothing; a zero base means unprogrammed.
module dcd_base_regs #(
    parameter int AW      = 16,
    parameter int NUM_WIN = 5,
    localparam int SW     = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SW-1:0]                 cfg_sel,
    input  logic [AW-1:0]                 cfg_wdata,
    output logic [NUM_WIN-1:0][AW-1:0]    base_o
);
    logic [NUM_WIN-1:0][AW-1:0] base_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_base
        // Load the base of window g on a nonzero write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[g] <= '0;
            else if (cfg_we && (cfg_sel == SW'(g)) && (cfg_wdata != '0))
                base_q[g] <= cfg_wdata;
        end
    end

    assign base_o = base_q;

    AST_ZERO_BASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == '0) |=> $stable(base_o)); // R1
endmodule

// File: rtl/dcd_window.sv
// One address window: compares an address against base and base+SIZE.
// Assumes SIZE fits in OW offset bits; the upper bound is computed one bit wider so it never wraps.
module dcd_window #(
    parameter int AW   = 16,
    parameter int SIZE = 8,
    parameter int OW   = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic [OW-1:0] ofs_o
);
    logic [AW:0] lim;

    // Range test with a widened limit.
    always_comb begin
        lim   = {1'b0, base_i} + (AW+1)'(SIZE);
        hit_o = (base_i != '0) && (addr_i >= base_i) && ({1'b0, addr_i} < lim);
        ofs_o = addr_i[OW-1:0] - base_i[OW-1:0];
    end

    initial begin
        assert (SIZE >= 1 && SIZE <= (1 << OW)) else $error("window size does not fit offset width");
    end
endmodule

// File: rtl/dcd_sel_shadow.sv
// Shadow of the master/slave select bit, one per channel.
// Assumes the caller asserts upd_en only for accepted select-register writes.
module dcd_sel_shadow #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_chan,
    input  logic              upd_bit,
    output logic [NUM_CH-1:0] shadow_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Latch the select bit of channel c on its select write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_o[c] <= 1'b0;
            else if (upd_en && (upd_chan == 1'(c)))
                shadow_o[c] <= upd_bit;
        end
    end

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(shadow_o)); // R5
endmodule

// File: rtl/dchan_io_decode.sv
// Top of the dual-channel IO address decoder.
// Classifies each access into window kind, channel, offset and device, or flags an error.
// Assumes one access per cycle; results are registered and appear one cycle later.
module dchan_io_decode
    import dcd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CMD_SIZE  = 8,
    parameter int CTRL_SIZE = 4,
    parameter int BM_SIZE   = 16,
    parameter int BM_SPLIT  = 8,
    parameter int SEL_OFF   = 6,
    parameter int SEL_BIT   = 4,
    localparam int MAXW     = (BM_SIZE > CMD_SIZE) ?
                              ((BM_SIZE > CTRL_SIZE) ? BM_SIZE : CTRL_SIZE) :
                              ((CMD_SIZE > CTRL_SIZE) ? CMD_SIZE : CTRL_SIZE),
    localparam int OW       = (MAXW > 1) ? $clog2(MAXW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_space_en,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    input  logic [7:0]    acc_wdata,
    output logic          dec_valid,
    output logic          dec_err,
    output logic [1:0]    dec_kind,
    output logic          dec_chan,
    output logic [OW-1:0] dec_offset,
    output logic [1:0]    dec_dev
);
    localparam int IW = $clog2(NUM_WIN);

    logic [NUM_WIN-1:0][AW-1:0] base;
    logic [NUM_WIN-1:0]         win_hit;
    logic [NUM_WIN-1:0][OW-1:0] win_ofs;
    logic [1:0]                 shadow;

    logic          hit_any;
    logic [IW-1:0] hit_idx;
    logic [OW-1:0] ofs;
    win_kind_e     kind;
    logic          chan;
    logic          size_ok;
    logic          accept;
    logic          reject;
    logic          sel_upd;
    logic          dev_bit;

    dcd_base_regs #(.AW(AW), .NUM_WIN(NUM_WIN)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int WSIZE = (w == W_BM) ? BM_SIZE :
                               ((w % 2 == 0) ? CMD_SIZE : CTRL_SIZE);
        dcd_window #(.AW(AW), .SIZE(WSIZE), .OW(OW)) u_win (
            .base_i (base[w]),
            .addr_i (acc_addr),
            .hit_o  (win_hit[w]),
            .ofs_o  (win_ofs[w])
        );
    end

    // Lowest-index matching window wins.
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                hit_any = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    // Kind, channel, size legality and acceptance of the current access.
    always_comb begin
        ofs  = win_ofs[hit_idx];
        kind = kind_of(int'(hit_idx));
        if (int'(hit_idx) == W_BM)
            chan = (ofs >= OW'(BM_SPLIT));
        else
            chan = (int'(hit_idx) >= W_SCMD);
        case (acc_size_e'(acc_size))
            SZ_BYTE, SZ_WORD: size_ok = 1'b1;
            SZ_DWORD:         size_ok = (kind == KIND_BM);
            default:          size_ok = 1'b0;
        endcase
        accept  = acc_valid && io_space_en && hit_any && size_ok;
        reject  = acc_valid && io_space_en && !accept;
        sel_upd = accept && acc_write && (kind == KIND_CMD) && (ofs == OW'(SEL_OFF));
        dev_bit = sel_upd ? acc_wdata[SEL_BIT] : shadow[chan];
    end

    dcd_sel_shadow #(.NUM_CH(2)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (sel_upd),
        .upd_chan (chan),
        .upd_bit  (acc_wdata[SEL_BIT]),
        .shadow_o (shadow)
    );

    // Register the decode result; fields stay zero unless the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_err    <= 1'b0;
            dec_kind   <= KIND_NONE;
            dec_chan   <= 1'b0;
            dec_offset <= '0;
            dec_dev    <= '0;
        end else begin
            dec_valid  <= accept;
            dec_err    <= reject;
            dec_kind   <= accept ? kind : KIND_NONE;
            dec_chan   <= accept ? chan : 1'b0;
            dec_offset <= accept ? ofs : '0;
            dec_dev    <= accept ? {chan, dev_bit} : 2'b00;
        end
    end

    AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_err)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!dec_valid && !dec_err && dec_dev == 2'b00)); // R10
    AST_IO_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !io_space_en) |=> (!dec_valid && !dec_err)); // R8
    AST_NO_WIDE_TASKFILE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size == 2'd2) |=> !(dec_valid && dec_kind != 2'd3)); // R7
    AST_BM_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 2'd3) |-> (dec_chan == (dec_offset >= OW'(BM_SPLIT)))); // R3
    AST_DEV_ON_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_dev[1] == dec_chan)); // R5
endmodule

// File: tb/tb_dchan_io_decode.sv
module tb_dchan_io_decode;
    localparam int AW = 16;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          io_space_en;
    logic          cfg_we;
    logic [2:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          acc_valid;
    logic          acc_write;
    logic [1:0]    acc_size;
    logic [AW-1:0] acc_addr;
    logic [7:0]    acc_wdata;
    logic          dec_valid;
    logic          dec_err;
    logic [1:0]    dec_kind;
    logic          dec_chan;
    logic [OW-1:0] dec_offset;
    logic [1:0]    dec_dev;

    always #2 clk = ~clk;

    dchan_io_decode dut (
        .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .dec_valid(dec_valid), .dec_err(dec_err), .dec_kind(dec_kind),
        .dec_chan(dec_chan), .dec_offset(dec_offset), .dec_dev(dec_dev)
    );

    // Reference model state
    int    base_m [5];
    int    wsize  [5] = '{8, 4, 8, 4, 16};
    int    shd    [2];
    int    e_valid, e_err, e_kind, e_chan, e_off, e_dev;
    string e_tag;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    task automatic compare();
        total++;
        if (dec_valid !== 1'(e_valid) || dec_err !== 1'(e_err) || dec_kind !== 2'(e_kind) ||
            dec_chan !== 1'(e_chan) || dec_offset !== 4'(e_off) || dec_dev !== 2'(e_dev)) begin
            bad++;
            $display("FAIL %s: actual v=%0d e=%0d k=%0d c=%0d o=%0d d=%0d expected v=%0d e=%0d k=%0d c=%0d o=%0d d=%0d",
                     e_tag, dec_valid, dec_err, dec_kind, dec_chan, dec_offset, dec_dev,
                     e_valid, e_err, e_kind, e_chan, e_off, e_dev);
        end
    endtask

    // Behavioural prediction of one cycle, then state update.
    task automatic model(input bit ioen, input bit cwe, input int csel, input int cdata,
                         input bit av, input bit aw, input int asz, input int aa, input int ad);
        int hit = -1;
        int off = 0;
        int kind = 0;
        int ch = 0;
        bit ok;
        for (int i = 0; i < 5; i++) begin
            if (hit < 0 && base_m[i] != 0 && aa >= base_m[i] && aa < base_m[i] + wsize[i]) begin
                hit = i;
                off = aa - base_m[i];
            end
        end
        if (hit >= 0) begin
            kind = (hit == 4) ? 3 : ((hit % 2 == 0) ? 1 : 2);
            ch   = (hit == 4) ? ((off >= 8) ? 1 : 0) : hit / 2;
        end
        ok = av && ioen && hit >= 0 && (asz < 2 || (asz == 2 && hit == 4));
        e_valid = ok;
        e_err   = (av && ioen && !ok) ? 1 : 0;
        if (ok) begin
            if (aw && kind == 1 && off == 6) shd[ch] = (ad >> 4) & 1;
            e_kind = kind; e_chan = ch; e_off = off; e_dev = 2 * ch + shd[ch];
        end else begin
            e_kind = 0; e_chan = 0; e_off = 0; e_dev = 0;
        end
        if (cwe && csel < 5 && cdata != 0) base_m[csel] = cdata;
    endtask

    task automatic step(input bit ioen, input bit cwe, input int csel, input int cdata,
                        input bit av, input bit aw, input int asz, input int aa, input int ad,
                        input string tag);
        @(negedge clk);
        compare();
        io_space_en = ioen; cfg_we = cwe; cfg_sel = 3'(csel); cfg_wdata = AW'(cdata);
        acc_valid = av; acc_write = aw; acc_size = 2'(asz); acc_addr = AW'(aa); acc_wdata = 8'(ad);
        model(ioen, cwe, csel, cdata, av, aw, asz, aa, ad);
        e_tag = tag;
    endtask

    task automatic cfg(input int sel, input int val, input string tag);
        step(1, 1, sel, val, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic acc(input bit w, input int sz, input int a, input int d, input string tag);
        step(1, 0, 0, 0, 1, w, sz, a, d, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_space_en = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_size = '0; acc_addr = '0; acc_wdata = '0;
        for (int i = 0; i < 5; i++) base_m[i] = 0;
        shd[0] = 0; shd[1] = 0;
        e_valid = 0; e_err = 0; e_kind = 0; e_chan = 0; e_off = 0; e_dev = 0;
        e_tag = "R10 reset state";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;

        acc(0, 0, 16'h01F0, 0, "R1 unprogrammed window misses");
        cfg(0, 16'h01F0, "R1 program");
        cfg(1, 16'h03F4, "R1 program");
        cfg(2, 16'h0170, "R1 program");
        cfg(3, 16'h0374, "R1 program");
        cfg(4, 16'hC000, "R1 program");
        cfg(0, 0, "R1 zero write");
        acc(0, 0, 16'h01F2, 0, "R1 R6 base kept, master after reset");
        acc(0, 1, 16'h03F7, 0, "R2 primary control last byte");
        acc(0, 0, 16'h03F8, 0, "R9 miss past control");
        acc(0, 0, 16'h0177, 0, "R2 secondary command");
        acc(0, 0, 16'h0374, 0, "R2 secondary control");
        acc(0, 2, 16'hC007, 0, "R3 bm primary half");
        acc(0, 2, 16'hC008, 0, "R3 bm secondary half");
        acc(0, 0, 16'hC00F, 0, "R3 bm last byte");
        acc(0, 0, 16'hC010, 0, "R9 miss past bm");
        acc(0, 0, 16'h0000, 0, "R9 back-to-back miss");
        acc(1, 0, 16'h01F6, 8'h10, "R5 select slave primary");
        acc(0, 0, 16'h01F0, 0, "R5 primary now slave");
        acc(0, 0, 16'h0170, 0, "R5 secondary still master");
        acc(0, 0, 16'h01F6, 8'h00, "R5 read of select keeps");
        acc(1, 0, 16'h0176, 8'h10, "R5 select slave secondary");
        acc(0, 0, 16'hC00A, 0, "R5 bm uses secondary shadow");
        acc(1, 0, 16'h01F6, 8'hEF, "R5 select master primary");
        acc(1, 0, 16'h01F5, 8'hFF, "R5 other offset ignored");
        acc(1, 0, 16'h03F6, 8'hFF, "R5 control write ignored");
        acc(0, 0, 16'h01F0, 0, "R5 primary master");
        acc(1, 2, 16'h01F6, 8'h10, "R7 dword to command rejected");
        acc(0, 0, 16'h01F0, 0, "R7 no shadow change");
        acc(0, 2, 16'h03F4, 0, "R7 dword to control rejected");
        acc(0, 3, 16'hC000, 0, "R7 illegal size rejected");
        step(0, 0, 0, 0, 1, 1, 0, 16'h01F6, 8'h10, "R8 io off select write");
        step(0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R8 io off miss silent");
        acc(0, 0, 16'h01F0, 0, "R8 shadow unchanged");
        cfg(2, 16'h01F0, "R4 overlap set");
        acc(0, 0, 16'h01F3, 0, "R4 primary command wins");
        cfg(2, 16'h0170, "R4 restore");
        cfg(4, 16'hFFF8, "R2 bm at top");
        acc(0, 0, 16'hFFFF, 0, "R2 top address no wrap");
        acc(0, 0, 16'hFFF8, 0, "R2 top window first byte");
        acc(0, 0, 16'h0000, 0, "R2 wrap miss");
        step(1, 1, 0, 16'h1000, 1, 0, 0, 16'h01F1, 0, "R1 same-cycle cfg uses old base");
        acc(0, 0, 16'h01F1, 0, "R1 moved base misses");
        acc(0, 0, 16'h1007, 0, "R1 new base hits");
        cfg(0, 16'h01F0, "R1 restore");
        cfg(4, 16'hC000, "R1 restore");

        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 4);
            int bases[5] = '{16'h01F0, 16'h03F4, 16'h0170, 16'h0374, 16'hC000};
            int a = bases[pick] + $urandom_range(0, 19) - 2;
            bit en = ($urandom_range(0, 9) != 0);
            step(en, 0, 0, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
                 $urandom_range(0, 3), a & 16'hFFFF, $urandom_range(0, 255),
                 "R2 R3 R5 R7 R9 random");
        end
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule